// File: doc/BRIEF.md
# Interrupt redirection table controller

This block keeps a table of 64-bit redirection entries, one per interrupt input line, and turns them into delivery pulses aimed at a set of processors. Software sees each entry as two 32-bit words. A register write port carries an entry index and a half select, and a read returns the selected half at once. On a write to the lower half, the block keeps the remote-IRR bit that the hardware owns and clears the delivery status bit. After every accepted write, and after every end-of-interrupt clear, a small state machine looks again at the touched entry. If the entry is level-triggered, unmasked, has remote-IRR clear and its line is high, the state machine sets remote-IRR and emits a one-cycle delivery.

The delivery carries the entry index, the entry's vector and a processor bitmask. The bitmask comes from the destination field and the destination mode, matched against a per-processor table. Each row of that table holds a present flag, a physical ID and a logical ID, and the rows are loaded through a separate configuration port.

The control state machine has three states. `S_IDLE` waits for a command. The transition `IDLE->EVAL` is taken when a register write or an end-of-interrupt clear is accepted. `S_EVAL` looks at the touched entry. It takes `EVAL->DELIVER` when the entry is eligible, setting remote-IRR and capturing the delivery, and `EVAL->IDLE` when it is not. `S_DELIVER` drives the delivery pulse and always takes `DELIVER->IDLE`.

Top module: `irq_redir_ctl`

## Requirements
- R1: After reset every entry reads 0x0001_0000 in its lower word (masked, everything else zero) and 0 in its upper word. `busy` and `dlv_valid` are low.
- R2: A write with `reg_hi_sel`=1 replaces bits 63:32 of the entry and leaves bits 31:0 unchanged. The destination ID is bits 63:56.
- R3: A write with `reg_hi_sel`=0 replaces bits 31:0, except that bit 14 (remote-IRR) keeps its old value and bit 12 (delivery status) becomes 0. The other lower-word fields are the vector in bits 7:0, the destination mode in bit 11 (0 physical, 1 logical), the trigger mode in bit 15 (1 level) and the mask in bit 16 (1 masked).
- R4: After an accepted write, if the entry is level-triggered, unmasked, has remote-IRR 0 and its `line_level` bit is 1, `dlv_valid` is high for exactly one cycle, two clock edges after the write edge, and remote-IRR becomes 1. Otherwise no delivery happens; this includes edge-triggered entries, masked entries and entries whose line is low.
- R5: During the delivery cycle, `dlv_idx` is the entry index and `dlv_vector` is the entry's bits 7:0.
- R6: In physical mode with destination 0xFF, `dlv_mask` has a bit set for every processor that is marked present.
- R7: In physical mode with any other destination, `dlv_mask` has only the bit of the lowest-numbered present processor whose physical ID equals the destination. If no present processor matches, `dlv_mask` is 0.
- R8: In logical mode with destination 0, `dlv_mask` is 0.
- R9: In logical mode with a nonzero destination, `dlv_mask` sets the bit of every present processor whose logical ID shares at least one set bit with the destination.
- R10: An accepted `eoi_en` clears the remote-IRR bit of entry `eoi_idx`. The entry is then examined as in R4, so an eligible entry whose line is still high is delivered again.
- R11: `busy` is high while the state machine is not idle. Register writes and end-of-interrupt clears presented while `busy` is high are ignored. When a write and a clear arrive in the same idle cycle, the write wins and the clear is dropped.
- R12: `reg_rdata` returns, without a clock edge, the half of entry `reg_idx` selected by `reg_hi_sel`. The lower word shows the current remote-IRR and delivery status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Entry index for writes and reads |
| reg_hi_sel | input | 1 | 1 selects the upper word, 0 the lower word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected half |
| eoi_en | input | 1 | End-of-interrupt clear strobe |
| eoi_idx | input | IDX_W | Entry whose remote-IRR is cleared |
| line_level | input | N_ENT | Current level of each interrupt input (1 = asserted) |
| cfg_wr_en | input | 1 | Processor table write strobe |
| cfg_cpu | input | CPU_W | Processor row to write |
| cfg_present | input | 1 | Processor present flag |
| cfg_phys_id | input | 8 | Physical ID of the processor |
| cfg_log_id | input | 8 | Logical ID of the processor |
| busy | output | 1 | State machine is not idle; commands are ignored |
| dlv_valid | output | 1 | One-cycle delivery pulse |
| dlv_idx | output | IDX_W | Entry index of the delivery |
| dlv_vector | output | 8 | Vector of the delivery |
| dlv_mask | output | N_CPU | Target processor bitmask |

## Verification
Several properties are checked on every cycle: a delivery never lasts more than one cycle, the remote-IRR bit of the delivered entry is set while the delivery is shown, and a lower-word read never shows delivery status set. The delivery mask only names processors that were present, it is at most one-hot for a physical non-broadcast destination, and it is empty for a logical zero destination. Other behaviours need the bench's scenarios. These are the merge rules for each half on writes, whether a delivery fires at all for a given mix of trigger, mask, remote-IRR and line, and the exact mask values for broadcast, duplicate physical IDs, no match and logical overlaps. The re-delivery after an end-of-interrupt clear and the dropping of commands while busy are also shown only by the bench.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    localparam int WORD_W    = 32;
    localparam int ID_W      = 8;
    localparam int VEC_MSB   = 7;
    localparam int DMODE_BIT = 11;
    localparam int DSTAT_BIT = 12;
    localparam int RIRR_BIT  = 14;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    localparam int DEST_LSB  = 56;
    localparam int DEST_MSB  = 63;

    localparam logic [WORD_W-1:0] LO_RESET = 32'h0001_0000;
    localparam logic [ID_W-1:0]   BCAST_ID = 8'hFF;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_EVAL    = 2'd1,
        S_DELIVER = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/irq_rte_table.sv
module irq_rte_table
    import irq_redir_pkg::*;
#(
    parameter int N_ENT = 24,
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_hi,
    output logic [WORD_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  ev_idx,
    output logic [ID_W-1:0]   ev_vector,
    output logic [ID_W-1:0]   ev_dest,
    output logic              ev_dmode,
    output logic              ev_level,
    output logic              ev_masked,
    output logic              ev_irr,
    output logic [N_ENT-1:0]  irr_bits
);

    logic [2*WORD_W-1:0] ent_arr [N_ENT];

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_ent
            logic [2*WORD_W-1:0] ent_q;
            logic [WORD_W-1:0]   lo_merge;
            logic                hit_wr;
            logic                hit_clr;
            logic                hit_set;

            assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(g));
            assign hit_clr = clr_en && (clr_idx == IDX_W'(g));
            assign hit_set = set_en && (set_idx == IDX_W'(g));

            // lower-word merge: status bits belong to hardware
            always_comb begin
                lo_merge            = wr_data;
                lo_merge[DSTAT_BIT] = 1'b0;
                lo_merge[RIRR_BIT]  = ent_q[RIRR_BIT];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent_q <= {{WORD_W{1'b0}}, LO_RESET};
                end else if (hit_wr) begin
                    if (wr_hi) begin
                        ent_q[2*WORD_W-1:WORD_W] <= wr_data;
                    end else begin
                        ent_q[WORD_W-1:0] <= lo_merge;
                    end
                end else if (hit_set) begin
                    ent_q[RIRR_BIT] <= 1'b1;
                end else if (hit_clr) begin
                    ent_q[RIRR_BIT] <= 1'b0;
                end
            end

            assign ent_arr[g]  = ent_q;
            assign irr_bits[g] = ent_q[RIRR_BIT];
        end
    endgenerate

    logic rd_ok;
    logic ev_ok;

    assign rd_ok = (int'(rd_idx) < N_ENT);
    assign ev_ok = (int'(ev_idx) < N_ENT);

    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            rd_data = rd_hi ? ent_arr[rd_idx][2*WORD_W-1:WORD_W]
                            : ent_arr[rd_idx][WORD_W-1:0];
        end
    end

    always_comb begin
        ev_vector = '0;
        ev_dest   = '0;
        ev_dmode  = 1'b0;
        ev_level  = 1'b0;
        ev_masked = 1'b1;
        ev_irr    = 1'b0;
        if (ev_ok) begin
            ev_vector = ent_arr[ev_idx][VEC_MSB:0];
            ev_dest   = ent_arr[ev_idx][DEST_MSB:DEST_LSB];
            ev_dmode  = ent_arr[ev_idx][DMODE_BIT];
            ev_level  = ent_arr[ev_idx][TRIG_BIT];
            ev_masked = ent_arr[ev_idx][MASK_BIT];
            ev_irr    = ent_arr[ev_idx][RIRR_BIT];
        end
    end

endmodule

// File: rtl/irq_cpu_table.sv
module irq_cpu_table
    import irq_redir_pkg::*;
#(
    parameter int N_CPU = 8,
    parameter int CPU_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CPU_W-1:0]      wr_cpu,
    input  logic                  wr_present,
    input  logic [ID_W-1:0]       wr_phys,
    input  logic [ID_W-1:0]       wr_log,
    output logic [N_CPU-1:0]      present,
    output logic [N_CPU*ID_W-1:0] phys_ids,
    output logic [N_CPU*ID_W-1:0] log_ids
);

    generate
        for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
            logic hit;
            assign hit = wr_en && (wr_cpu == CPU_W'(c));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    present[c]             <= 1'b0;
                    phys_ids[c*ID_W +: ID_W] <= '0;
                    log_ids[c*ID_W +: ID_W]  <= '0;
                end else if (hit) begin
                    present[c]             <= wr_present;
                    phys_ids[c*ID_W +: ID_W] <= wr_phys;
                    log_ids[c*ID_W +: ID_W]  <= wr_log;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_dest_decode.sv
module irq_dest_decode
    import irq_redir_pkg::*;
#(
    parameter int N_CPU = 8
) (
    input  logic [ID_W-1:0]       dest,
    input  logic                  logical,
    input  logic [N_CPU-1:0]      present,
    input  logic [N_CPU*ID_W-1:0] phys_ids,
    input  logic [N_CPU*ID_W-1:0] log_ids,
    output logic [N_CPU-1:0]      tgt_mask
);

    logic [N_CPU-1:0] phys_hit;
    logic [N_CPU-1:0] log_hit;
    logic [N_CPU-1:0] phys_first;

    generate
        for (genvar c = 0; c < N_CPU; c++) begin : g_match
            assign phys_hit[c] = present[c] && (phys_ids[c*ID_W +: ID_W] == dest);
            assign log_hit[c]  = present[c] && ((log_ids[c*ID_W +: ID_W] & dest) != '0);
        end
    endgenerate

    // isolate lowest set bit: first matching processor wins
    assign phys_first = phys_hit & (~phys_hit + N_CPU'(1));

    always_comb begin
        if (!logical) begin
            tgt_mask = (dest == BCAST_ID) ? present : phys_first;
        end else begin
            tgt_mask = (dest == '0) ? '0 : log_hit;
        end
    end

endmodule

// File: rtl/irq_ctl_fsm.sv
module irq_ctl_fsm
    import irq_redir_pkg::*;
#(
    parameter int N_CPU = 8,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             eoi_req,
    input  logic [IDX_W-1:0] eoi_idx,
    input  logic             eligible,
    input  logic [ID_W-1:0]  vector_in,
    input  logic [N_CPU-1:0] mask_in,
    output logic             accept_wr,
    output logic             accept_eoi,
    output logic             fire,
    output logic [IDX_W-1:0] pend_idx,
    output logic             busy,
    output logic             dlv_valid,
    output logic [IDX_W-1:0] dlv_idx,
    output logic [ID_W-1:0]  dlv_vector,
    output logic [N_CPU-1:0] dlv_mask
);

    ctl_state_e state_q;
    ctl_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (wr_req || eoi_req) state_d = S_EVAL;
            S_EVAL:    state_d = eligible ? S_DELIVER : S_IDLE;
            S_DELIVER: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        accept_wr  = (state_q == S_IDLE) && wr_req;
        accept_eoi = (state_q == S_IDLE) && eoi_req && !wr_req;
        fire       = (state_q == S_EVAL) && eligible;
        busy       = (state_q != S_IDLE);
        dlv_valid  = (state_q == S_DELIVER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_idx   <= '0;
            dlv_idx    <= '0;
            dlv_vector <= '0;
            dlv_mask   <= '0;
        end else begin
            if (accept_wr) begin
                pend_idx <= wr_idx;
            end else if (accept_eoi) begin
                pend_idx <= eoi_idx;
            end
            if (fire) begin
                dlv_idx    <= pend_idx;
                dlv_vector <= vector_in;
                dlv_mask   <= mask_in;
            end
        end
    end

endmodule

// File: rtl/irq_redir_ctl.sv
module irq_redir_ctl
    import irq_redir_pkg::*;
#(
    parameter int N_ENT = 24,
    parameter int N_CPU = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              reg_hi_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              eoi_en,
    input  logic [IDX_W-1:0]  eoi_idx,
    input  logic [N_ENT-1:0]  line_level,
    input  logic              cfg_wr_en,
    input  logic [CPU_W-1:0]  cfg_cpu,
    input  logic              cfg_present,
    input  logic [ID_W-1:0]   cfg_phys_id,
    input  logic [ID_W-1:0]   cfg_log_id,
    output logic              busy,
    output logic              dlv_valid,
    output logic [IDX_W-1:0]  dlv_idx,
    output logic [ID_W-1:0]   dlv_vector,
    output logic [N_CPU-1:0]  dlv_mask
);

    logic                  accept_wr;
    logic                  accept_eoi;
    logic                  fire;
    logic [IDX_W-1:0]      pend_idx;
    logic [ID_W-1:0]       ev_vector;
    logic [ID_W-1:0]       ev_dest;
    logic                  ev_dmode;
    logic                  ev_level;
    logic                  ev_masked;
    logic                  ev_irr;
    logic [N_ENT-1:0]      irr_bits;
    logic                  line_at;
    logic                  eligible;
    logic [N_CPU-1:0]      present;
    logic [N_CPU*ID_W-1:0] phys_ids;
    logic [N_CPU*ID_W-1:0] log_ids;
    logic [N_CPU-1:0]      tgt_mask;

    irq_rte_table #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept_wr),
        .wr_idx    (reg_idx),
        .wr_hi     (reg_hi_sel),
        .wr_data   (reg_wdata),
        .clr_en    (accept_eoi),
        .clr_idx   (eoi_idx),
        .set_en    (fire),
        .set_idx   (pend_idx),
        .rd_idx    (reg_idx),
        .rd_hi     (reg_hi_sel),
        .rd_data   (reg_rdata),
        .ev_idx    (pend_idx),
        .ev_vector (ev_vector),
        .ev_dest   (ev_dest),
        .ev_dmode  (ev_dmode),
        .ev_level  (ev_level),
        .ev_masked (ev_masked),
        .ev_irr    (ev_irr),
        .irr_bits  (irr_bits)
    );

    irq_cpu_table #(.N_CPU(N_CPU), .CPU_W(CPU_W)) u_cpus (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_cpu     (cfg_cpu),
        .wr_present (cfg_present),
        .wr_phys    (cfg_phys_id),
        .wr_log     (cfg_log_id),
        .present    (present),
        .phys_ids   (phys_ids),
        .log_ids    (log_ids)
    );

    irq_dest_decode #(.N_CPU(N_CPU)) u_decode (
        .dest     (ev_dest),
        .logical  (ev_dmode),
        .present  (present),
        .phys_ids (phys_ids),
        .log_ids  (log_ids),
        .tgt_mask (tgt_mask)
    );

    assign line_at  = (int'(pend_idx) < N_ENT) ? line_level[pend_idx] : 1'b0;
    assign eligible = ev_level && !ev_masked && !ev_irr && line_at;

    irq_ctl_fsm #(.N_CPU(N_CPU), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (reg_wr_en),
        .wr_idx     (reg_idx),
        .eoi_req    (eoi_en),
        .eoi_idx    (eoi_idx),
        .eligible   (eligible),
        .vector_in  (ev_vector),
        .mask_in    (tgt_mask),
        .accept_wr  (accept_wr),
        .accept_eoi (accept_eoi),
        .fire       (fire),
        .pend_idx   (pend_idx),
        .busy       (busy),
        .dlv_valid  (dlv_valid),
        .dlv_idx    (dlv_idx),
        .dlv_vector (dlv_vector),
        .dlv_mask   (dlv_mask)
    );

endmodule

// File: rtl/irq_redir_ctl_chk.sv
module irq_redir_ctl_chk
    import irq_redir_pkg::*;
#(
    parameter int N_ENT = 24,
    parameter int N_CPU = 8,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dlv_valid,
    input logic [IDX_W-1:0] dlv_idx,
    input logic [N_CPU-1:0] dlv_mask,
    input logic             rd_hi,
    input logic             rd_dstat,
    input logic [N_ENT-1:0] irr_bits,
    input logic [N_CPU-1:0] present,
    input logic [ID_W-1:0]  ev_dest,
    input logic             ev_dmode
);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |=> !dlv_valid);

    a_r4_irr_set_on_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> irr_bits[dlv_idx]);

    a_r3_dstat_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hi |-> !rd_dstat);

    a_r6_mask_only_present: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ((dlv_mask & ~$past(present)) == '0));

    a_r7_phys_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !ev_dmode && (ev_dest != BCAST_ID)) |-> $onehot0(dlv_mask));

    a_r8_logical_zero_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && ev_dmode && (ev_dest == '0)) |-> (dlv_mask == '0));

endmodule

bind irq_redir_ctl irq_redir_ctl_chk #(.N_ENT(N_ENT), .N_CPU(N_CPU), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dlv_valid (dlv_valid),
    .dlv_idx   (dlv_idx),
    .dlv_mask  (dlv_mask),
    .rd_hi     (reg_hi_sel),
    .rd_dstat  (reg_rdata[12]),
    .irr_bits  (irr_bits),
    .present   (present),
    .ev_dest   (ev_dest),
    .ev_dmode  (ev_dmode)
);

// File: tb/irq_redir_ctl_tb.sv
`timescale 1ns/1ps
module irq_redir_ctl_tb;

    localparam int N_ENT = 24;
    localparam int N_CPU = 8;
    localparam int IDX_W = 5;
    localparam int CPU_W = 3;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [7:0]       vec;
        logic [N_CPU-1:0] mask;
    } dlv_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [IDX_W-1:0] reg_idx = '0;
    logic reg_hi_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic eoi_en = 1'b0;
    logic [IDX_W-1:0] eoi_idx = '0;
    logic [N_ENT-1:0] line_level = '0;
    logic cfg_wr_en = 1'b0;
    logic [CPU_W-1:0] cfg_cpu = '0;
    logic cfg_present = 1'b0;
    logic [7:0] cfg_phys_id = '0;
    logic [7:0] cfg_log_id = '0;
    logic busy;
    logic dlv_valid;
    logic [IDX_W-1:0] dlv_idx;
    logic [7:0] dlv_vector;
    logic [N_CPU-1:0] dlv_mask;

    always #4 clk = ~clk;

    irq_redir_ctl #(.N_ENT(N_ENT), .N_CPU(N_CPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_idx(reg_idx),
        .reg_hi_sel(reg_hi_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eoi_en(eoi_en), .eoi_idx(eoi_idx), .line_level(line_level),
        .cfg_wr_en(cfg_wr_en), .cfg_cpu(cfg_cpu), .cfg_present(cfg_present),
        .cfg_phys_id(cfg_phys_id), .cfg_log_id(cfg_log_id), .busy(busy),
        .dlv_valid(dlv_valid), .dlv_idx(dlv_idx), .dlv_vector(dlv_vector),
        .dlv_mask(dlv_mask)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    dlv_item_t exp_q[$];

    // reference model
    logic [31:0] m_lo [N_ENT];
    logic [31:0] m_hi [N_ENT];
    logic        m_pres [N_CPU];
    logic [7:0]  m_phys [N_CPU];
    logic [7:0]  m_log  [N_CPU];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N_CPU-1:0] ref_mask(input logic [7:0] d, input logic lmode);
        logic [N_CPU-1:0] m = '0;
        bit found = 0;
        for (int c = 0; c < N_CPU; c++) begin
            if (m_pres[c]) begin
                if (!lmode) begin
                    if (d == 8'hFF) m[c] = 1'b1;
                    else if (!found && m_phys[c] == d) begin m[c] = 1'b1; found = 1; end
                end else if (d != 8'h00 && (m_log[c] & d) != 8'h00) begin
                    m[c] = 1'b1;
                end
            end
        end
        return m;
    endfunction

    // R4 eligibility evaluated in the model; pushes the expected delivery
    task automatic model_eval(input int i);
        dlv_item_t it;
        if (m_lo[i][15] && !m_lo[i][16] && !m_lo[i][14] && line_level[i]) begin
            m_lo[i][14] = 1'b1;
            it.idx  = IDX_W'(i);
            it.vec  = m_lo[i][7:0];
            it.mask = ref_mask(m_hi[i][31:24], m_lo[i][11]);
            exp_q.push_back(it);
        end
    endtask

    task automatic wait_idle(input string tag);
        while (busy) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic reg_write(input int i, input bit hi, input logic [31:0] d, input string tag);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_idx = IDX_W'(i); reg_hi_sel = hi; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (hi) m_hi[i] = d;
        else m_lo[i] = {d[31:15], m_lo[i][14], d[13], 1'b0, d[11:0]};
        model_eval(i);
        wait_idle(tag);
    endtask

    task automatic eoi(input int i, input string tag);
        @(negedge clk);
        eoi_en = 1'b1; eoi_idx = IDX_W'(i);
        @(negedge clk);
        eoi_en = 1'b0;
        m_lo[i][14] = 1'b0;
        model_eval(i);
        wait_idle(tag);
    endtask

    task automatic read_chk(input int i, input bit hi, input string tag);
        logic [31:0] e;
        @(negedge clk);
        reg_idx = IDX_W'(i); reg_hi_sel = hi;
        #1;
        e = hi ? m_hi[i] : m_lo[i];
        check(reg_rdata === e, tag, reg_rdata, e);
    endtask

    task automatic cpu_cfg(input int c, input bit p, input logic [7:0] ph, input logic [7:0] lg);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_cpu = CPU_W'(c); cfg_present = p;
        cfg_phys_id = ph; cfg_log_id = lg;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        m_pres[c] = p; m_phys[c] = ph; m_log[c] = lg;
    endtask

    // monitor: compare deliveries against the scoreboard queue (R5)
    always @(negedge clk) begin
        if (rst_n && dlv_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected delivery", dlv_idx, 0);
            end else begin
                dlv_item_t e;
                e = exp_q.pop_front();
                check(dlv_idx == e.idx, "R5 delivery index", dlv_idx, e.idx);
                check(dlv_vector == e.vec, "R5 delivery vector", dlv_vector, e.vec);
                check(dlv_mask == e.mask, "R6/R7/R8/R9 delivery mask", dlv_mask, e.mask);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N_ENT; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = '0; end
        for (int c = 0; c < N_CPU; c++) begin m_pres[c] = 0; m_phys[c] = 0; m_log[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(dlv_valid == 1'b0, "R1 no delivery after reset", dlv_valid, 0);
        read_chk(0, 0, "R1 entry 0 low reset");
        read_chk(23, 1, "R1 entry 23 high reset");

        cpu_cfg(0, 1, 8'h10, 8'h01);
        cpu_cfg(1, 1, 8'h11, 8'h02);
        cpu_cfg(2, 1, 8'h12, 8'h04);
        cpu_cfg(3, 1, 8'h11, 8'h08);
        cpu_cfg(6, 0, 8'h33, 8'hFF);

        // R2 upper write keeps lower half
        reg_write(3, 1, 32'h1200_0000, "R2 no delivery on high write");
        read_chk(3, 1, "R2 high word");
        read_chk(3, 0, "R2 low unchanged");

        // R3 low write: remote-IRR kept, delivery status forced 0; edge -> none (R4)
        reg_write(3, 0, 32'h0000_5030, "R4 edge entry no delivery");
        read_chk(3, 0, "R3 low merge");

        // R4/R5/R7 level delivery, duplicate physical ID picks lowest CPU
        line_level[5] = 1'b1;
        reg_write(5, 1, 32'h1100_0000, "R4 high write masked none");
        reg_write(5, 0, 32'h0000_8041, "R4 level delivery");
        read_chk(5, 0, "R12 low shows remote-IRR");

        // R3: rewrite with IRR clear in data -> IRR kept, no redelivery
        reg_write(5, 0, 32'h0000_8041, "R3 IRR kept no redelivery");
        read_chk(5, 0, "R3 IRR still set");

        // R10 EOI with line high re-fires
        eoi(5, "R10 EOI redelivery");
        // R10 EOI with line low clears only
        line_level[5] = 1'b0;
        eoi(5, "R10 EOI line low none");
        read_chk(5, 0, "R10 IRR cleared");

        // R6 broadcast
        line_level[7] = 1'b1;
        reg_write(7, 1, 32'hFF00_0000, "R6 prep");
        reg_write(7, 0, 32'h0000_8022, "R6 broadcast delivery");

        // R7 no match
        line_level[8] = 1'b1;
        reg_write(8, 1, 32'h3300_0000, "R7 prep");
        reg_write(8, 0, 32'h0000_8023, "R7 no-match delivery");

        // R9 logical overlap
        line_level[9] = 1'b1;
        reg_write(9, 1, 32'h0600_0000, "R9 prep");
        reg_write(9, 0, 32'h0000_8855, "R9 logical delivery");

        // R8 logical zero destination
        line_level[10] = 1'b1;
        reg_write(10, 0, 32'h0000_8856, "R8 logical zero delivery");

        // R4 masked level entry: no delivery
        line_level[11] = 1'b1;
        reg_write(11, 0, 32'h0001_8010, "R4 masked none");

        // R11 writes while busy are dropped
        line_level[12] = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b1; reg_idx = 5'd12; reg_hi_sel = 1'b0; reg_wdata = 32'h0000_8077;
        @(negedge clk);
        m_lo[12] = 32'h0000_8077;
        model_eval(12);
        check(busy == 1'b1, "R11 busy after command", busy, 1);
        reg_idx = 5'd13; reg_hi_sel = 1'b1; reg_wdata = 32'hAB00_0000;
        @(negedge clk);
        reg_wr_en = 1'b0;
        wait_idle("R11 busy window delivery");
        read_chk(13, 1, "R11 write in busy ignored");

        // R11 write wins over simultaneous EOI
        @(negedge clk);
        reg_wr_en = 1'b1; reg_idx = 5'd14; reg_hi_sel = 1'b1; reg_wdata = 32'h0100_0000;
        eoi_en = 1'b1; eoi_idx = 5'd5;
        @(negedge clk);
        reg_wr_en = 1'b0; eoi_en = 1'b0;
        m_hi[14] = 32'h0100_0000;
        wait_idle("R11 write wins");
        read_chk(14, 1, "R11 write applied");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 all deliveries seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule